// File: doc/BRIEF.md
# Sampling ADC Capture Controller

This block runs a pipelined 14-bit sampling converter from the system clock and collects its results. It produces a free-running start-convert pulse whose period and high time are counted in system clock cycles. It holds the converter's active-low output enable asserted, so the converter always drives its parallel result. The converter returns each result one conversion late. The block therefore samples the 14-bit word and its overflow flag on the clock edge where a start pulse ends. The word present at that edge belongs to the conversion launched by the previous pulse.

Each captured word arrives in complementary offset binary. The block converts it to two's complement and tags it with a conversion index. It then offers the result on a valid/ready stream through a single-entry holding register. The first capture after reset has no conversion behind it and is discarded. A sample that arrives while the holding register is still occupied and the consumer is not ready is dropped, and a sticky overrun flag is raised.

Top module: `adc_capture_ctrl`

## Requirements
- R1: While reset is asserted, adcStart is 0, adcOeN is 1, outValid is 0 and overrun is 0.
- R2: From the first clock after reset is released, adcOeN is 0 and stays 0.
- R3: adcStart repeats with a period of cfgPeriod cycles from one rising edge to the next, and stays high for cfgPulse cycles. After reset these values are 10 and 5.
- R4: A cfgLoad pulse with cfgPulse of at least 1 and cfgPeriod greater than cfgPulse takes effect at the next period boundary.
- R5: A cfgLoad with cfgPulse equal to 0, or with cfgPeriod not greater than cfgPulse, is ignored, and the previous timing continues.
- R6: The word on adcData at the clock edge where adcStart falls is the result of the conversion started by the previous pulse. The capture at the first falling edge after reset is discarded, so the first word streamed carries index 0.
- R7: outData is the two's complement value 8191 minus the captured unsigned code. For example, code 0x0000 gives +8191, 0x3FFF gives -8192, 0x1FFF gives 0 and 0x2000 gives -1.
- R8: outOvf carries the adcOvf level that was captured with the same word.
- R9: outIdx is the conversion number counted from 0 after reset. It advances on every conversion, including dropped ones, so a drop leaves a gap.
- R10: A new sample that arrives while outValid is 1 and outReady is 0 is dropped, and overrun is set. overrun then stays 1 until reset.
- R11: While outValid is 1 and outReady is 0, outValid, outData, outOvf and outIdx hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | One-cycle strobe that requests new timing |
| cfgPeriod | input | 16 | Requested sample period in clock cycles |
| cfgPulse | input | 16 | Requested start-pulse high time in clock cycles |
| adcStart | output | 1 | Start-convert pulse to the converter |
| adcOeN | output | 1 | Active-low output enable to the converter |
| adcData | input | 14 | Converter result in complementary offset binary |
| adcOvf | input | 1 | Converter overflow flag |
| outValid | output | 1 | Stream word available |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 14 | Sample in two's complement |
| outOvf | output | 1 | Overflow flag of the sample |
| outIdx | output | 16 | Conversion index of the sample |
| overrun | output | 1 | Sticky flag: a sample was dropped |

## Verification
A behavioural converter in the bench returns each result one pulse late, about 20 ns after the rising edge. Its first four codes are the two extremes and the two codes around mid-scale, and the rest come from a seeded random source. Together they show the sign flip and the mid-scale boundary of the conversion, and whether the pipeline alignment is off by one. The consumer is always ready in one phase, randomly ready in another, and stalled for several periods in a third. This separates clean streaming from hold behaviour and from overrun with index gaps. The timing is measured at the default setting, after two valid reloads (one at the shortest legal period) and after two illegal reloads. This tells boundary-timed updates apart from rejected ones.

// File: rtl/adc_cap_pkg.sv
`timescale 1ns/1ps
package adc_cap_pkg;
  // Strobes handed from the timing control to the capture datapath.
  typedef struct packed {
    logic capture;   // this edge is the falling edge of a start pulse
    logic oeActive;  // converter output enable is asserted
  } capStrobe_t;
endpackage

// File: rtl/adc_cap_ctrl.sv
`timescale 1ns/1ps
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_PULSE  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0] cfgPulse,
  output logic             adcStart,
  output logic             adcOeN,
  output capStrobe_t       strobe
);
  localparam logic [CNT_W-1:0] RST_PERIOD = CNT_W'(DEF_PERIOD);
  localparam logic [CNT_W-1:0] RST_PULSE  = CNT_W'(DEF_PULSE);
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);

  logic [CNT_W-1:0] periodReg, pulseReg, pendPeriod, pendPulse, phaseCnt;
  logic startQ, oeNQ, cfgOk, atWrap, inPulse;

  always_comb begin
    cfgOk   = cfgLoad && (cfgPulse != '0) && (cfgPeriod > cfgPulse);
    atWrap  = (phaseCnt == periodReg - ONE);
    inPulse = (phaseCnt < pulseReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodReg  <= RST_PERIOD;
      pulseReg   <= RST_PULSE;
      pendPeriod <= RST_PERIOD;
      pendPulse  <= RST_PULSE;
      phaseCnt   <= '0;
      startQ     <= 1'b0;
      oeNQ       <= 1'b1;
    end else begin
      if (cfgOk) begin
        pendPeriod <= cfgPeriod;
        pendPulse  <= cfgPulse;
      end
      if (atWrap) begin
        phaseCnt  <= '0;
        periodReg <= cfgOk ? cfgPeriod : pendPeriod;
        pulseReg  <= cfgOk ? cfgPulse  : pendPulse;
      end else begin
        phaseCnt <= phaseCnt + ONE;
      end
      startQ <= inPulse;
      oeNQ   <= 1'b0;
    end
  end

  assign adcStart        = startQ;
  assign adcOeN          = oeNQ;
  assign strobe.capture  = startQ && !inPulse;
  assign strobe.oeActive = !oeNQ;

  assert_oe_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> !adcOeN);
  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < periodReg);
  assert_cfg_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pulseReg != '0) && (periodReg > pulseReg));
  assert_start_low_at_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (atWrap && (periodReg > pulseReg + ONE)) |=> !adcStart);
endmodule

// File: rtl/adc_cap_dp.sv
`timescale 1ns/1ps
module adc_cap_dp
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        strobe,
  input  logic [DATA_W-1:0] adcData,
  input  logic              adcOvf,
  input  logic              outReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outOvf,
  output logic [IDX_W-1:0]  outIdx,
  output logic              overrun
);
  localparam int MSB = DATA_W - 1;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic              primed, validQ, ovfQ, overrunQ, takeSample, roomFree;
  logic [DATA_W-1:0] tcWord, dataQ;
  logic [IDX_W-1:0]  idxCnt, idxQ;

  // Complementary offset binary to two's complement: invert, then flip MSB back.
  always_comb begin
    tcWord      = ~adcData;
    tcWord[MSB] = adcData[MSB];
    takeSample  = strobe.capture && strobe.oeActive && primed;
    roomFree    = !validQ || outReady;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed   <= 1'b0;
      validQ   <= 1'b0;
      dataQ    <= '0;
      ovfQ     <= 1'b0;
      idxQ     <= '0;
      idxCnt   <= '0;
      overrunQ <= 1'b0;
    end else begin
      if (strobe.capture && strobe.oeActive) primed <= 1'b1;
      if (takeSample) begin
        idxCnt <= idxCnt + IDX_ONE;
        if (roomFree) begin
          validQ <= 1'b1;
          dataQ  <= tcWord;
          ovfQ   <= adcOvf;
          idxQ   <= idxCnt;
        end else begin
          overrunQ <= 1'b1;
        end
      end else if (validQ && outReady) begin
        validQ <= 1'b0;
      end
    end
  end

  assign outValid = validQ;
  assign outData  = dataQ;
  assign outOvf   = ovfQ;
  assign outIdx   = idxQ;
  assign overrun  = overrunQ;

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outIdx) && $stable(outOvf)));
  assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  assert_overrun_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(outValid && !outReady && strobe.capture));
  assert_valid_on_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $past(strobe.capture));
endmodule

// File: rtl/adc_capture_ctrl.sv
`timescale 1ns/1ps
module adc_capture_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W     = 14,
  parameter int CNT_W      = 16,
  parameter int IDX_W      = 16,
  parameter int DEF_PERIOD = 10,
  parameter int DEF_PULSE  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [CNT_W-1:0]  cfgPeriod,
  input  logic [CNT_W-1:0]  cfgPulse,
  output logic              adcStart,
  output logic              adcOeN,
  input  logic [DATA_W-1:0] adcData,
  input  logic              adcOvf,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData,
  output logic              outOvf,
  output logic [IDX_W-1:0]  outIdx,
  output logic              overrun
);
  capStrobe_t strobe;

  adc_cap_ctrl #(.CNT_W(CNT_W), .DEF_PERIOD(DEF_PERIOD), .DEF_PULSE(DEF_PULSE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgPeriod(cfgPeriod),
    .cfgPulse(cfgPulse), .adcStart(adcStart), .adcOeN(adcOeN), .strobe(strobe)
  );

  adc_cap_dp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcData(adcData), .adcOvf(adcOvf),
    .outReady(outReady), .outValid(outValid), .outData(outData), .outOvf(outOvf),
    .outIdx(outIdx), .overrun(overrun)
  );
endmodule

// File: tb/adc_capture_ctrl_tb.sv
`timescale 1ns/1ps
module adc_capture_ctrl_tb;
  localparam int DW = 14, CW = 16, IW = 16;

  logic clk = 1'b0, rstN = 1'b0;
  always #5 clk = ~clk;

  logic cfgLoad = 1'b0;
  logic [CW-1:0] cfgPeriod = '0, cfgPulse = '0;
  logic [DW-1:0] adcData = '0;
  logic adcOvf = 1'b0, outReady = 1'b0;
  logic adcStart, adcOeN, outValid, outOvf, overrun;
  logic [DW-1:0] outData;
  logic [IW-1:0] outIdx;

  int total = 0, bad = 0;
  int readyMode = 0;
  int convN = 0, nXfer = 0, lastIdx = -1;
  bit seenGap = 0;
  logic [DW-1:0] codeMem [0:4095];
  logic ovfMem [0:4095];

  adc_capture_ctrl u_dut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgPeriod(cfgPeriod), .cfgPulse(cfgPulse),
    .adcStart(adcStart), .adcOeN(adcOeN), .adcData(adcData), .adcOvf(adcOvf),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outOvf(outOvf),
    .outIdx(outIdx), .overrun(overrun)
  );

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pickCode(int n);
    case (n)
      0: return 14'h0000;
      1: return 14'h3FFF;
      2: return 14'h1FFF;
      3: return 14'h2000;
      default: return DW'($urandom);
    endcase
  endfunction

  // Converter model: result of conversion n appears ~20 ns after pulse n+1 rises.
  always @(posedge adcStart) begin
    int n;
    n = convN;
    codeMem[n % 4096] = pickCode(n);
    ovfMem[n % 4096]  = (($urandom % 8) == 0);
    convN++;
    if (n > 0) begin
      adcData <= #20 codeMem[(n-1) % 4096];
      adcOvf  <= #20 ovfMem[(n-1) % 4096];
    end
  end

  always @(posedge clk) begin
    #1;
    if (readyMode == 1) outReady <= 1'b1;
    else if (readyMode == 2) outReady <= (($urandom % 10) < 7);
    else outReady <= 1'b0;
  end

  // Scoreboard on accepted words.
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      int idx, exp;
      idx = int'(outIdx);
      exp = 8191 - int'(codeMem[idx % 4096]);
      check(int'($signed(outData)) == exp, "R7 data", int'($signed(outData)), exp);
      check(outOvf == ovfMem[idx % 4096], "R8 ovf", int'(outOvf), int'(ovfMem[idx % 4096]));
      if (lastIdx < 0) check(idx == 0, "R6 first index", idx, 0);
      else check(idx > lastIdx, "R9 index order", idx, lastIdx + 1);
      if (lastIdx >= 0 && idx > lastIdx + 1) seenGap = 1;
      lastIdx = idx;
      nXfer++;
    end
  end

  task automatic measure(output int w, output int p);
    realtime t0, t1, t2;
    @(posedge adcStart); t0 = $realtime;
    @(negedge adcStart); t1 = $realtime;
    @(posedge adcStart); t2 = $realtime;
    w = int'((t1 - t0) / 10.0);
    p = int'((t2 - t0) / 10.0);
  endtask

  task automatic applyCfg(int per, int pul);
    @(negedge clk);
    cfgPeriod = CW'(per); cfgPulse = CW'(pul); cfgLoad = 1'b1;
    @(negedge clk);
    cfgLoad = 1'b0;
    repeat (2) @(posedge adcStart);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w, p, held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(adcStart == 1'b0, "R1 start", int'(adcStart), 0);
    check(adcOeN == 1'b1, "R1 oeN", int'(adcOeN), 1);
    check(outValid == 1'b0, "R1 valid", int'(outValid), 0);
    check(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(adcOeN == 1'b0, "R2 oeN", int'(adcOeN), 0);
    measure(w, p);
    check(w == 5, "R3 default width", w, 5);
    check(p == 10, "R3 default period", p, 10);

    readyMode = 1;
    wait (convN >= 40);
    readyMode = 2;
    wait (convN >= 140);
    @(negedge clk);
    check(overrun == 1'b0, "R10 no overrun yet", int'(overrun), 0);
    check(nXfer >= 130, "R6 stream count", nXfer, 130);

    readyMode = 0;
    repeat (6) @(posedge adcStart);
    @(negedge clk);
    check(overrun == 1'b1, "R10 overrun set", int'(overrun), 1);
    check(outValid == 1'b1, "R11 held valid", int'(outValid), 1);
    held = int'(outIdx);
    repeat (15) @(negedge clk);
    check(int'(outIdx) == held, "R11 held index", int'(outIdx), held);
    readyMode = 1;
    repeat (5) @(posedge adcStart);
    @(negedge clk);
    check(seenGap, "R9 gap after drop", int'(seenGap), 1);
    check(overrun == 1'b1, "R10 sticky", int'(overrun), 1);

    applyCfg(20, 8);
    measure(w, p);
    check(w == 8, "R4 width", w, 8);
    check(p == 20, "R4 period", p, 20);
    applyCfg(8, 8);
    measure(w, p);
    check(w == 8 && p == 20, "R5 equal rejected", p, 20);
    applyCfg(30, 0);
    measure(w, p);
    check(w == 8 && p == 20, "R5 zero pulse rejected", w, 8);
    applyCfg(4, 3);
    measure(w, p);
    check(w == 3, "R4 min width", w, 3);
    check(p == 4, "R4 min period", p, 4);
    held = nXfer;
    readyMode = 2;
    wait (convN >= 260);
    readyMode = 1;
    repeat (4) @(posedge adcStart);
    @(negedge clk);
    check(nXfer > held + 40, "R6 fast stream", nXfer - held, 41);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule